// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches a group of input pins and raises a single interrupt line when a programmed event is seen on any of them. Each pin is first passed through a two-flop synchronizer. A 3-bit selector per pin then picks what counts as an event. The choices are a falling edge, a rising edge, any edge, a sustained low level or a sustained high level. Detected events are held in a status register. Reading that register returns its contents and clears it.

A mask register decides which pins may assert the interrupt. Software changes the mask only through two write-one ports, one that sets bits and one that clears bits, so no read-modify-write is needed. An interrupt handler reads the status, ANDs it with the mask, services the pins that remain, and repeats until the result is zero.

Register map (byte offsets, 32-bit data): 0x0 enable-set (write), 0x4 enable-clear (write), 0x8 mask (read), 0xC status (read, clear on read). Read data is registered: it appears on `reg_rdata_o` in the cycle after the read strobe and holds until the next read.

Top module: `pin_evt_irq_ctrl`

## Requirements
- R1: After reset the mask and the status are zero, `irq_o` is low, and reads of offsets 0x8 and 0xC return 0.
- R2: Selector code 0 records a status bit on a high-to-low transition of the synchronized pin and not on a low-to-high transition.
- R3: Selector code 1 records a status bit on a low-to-high transition and not on a high-to-low transition.
- R4: Selector code 2 records a status bit on either transition.
- R5: Selector code 3 sets the status bit on every cycle the synchronized pin is low. If the pin is still low, the bit is present again after a clearing read.
- R6: Selector code 4 sets the status bit on every cycle the synchronized pin is high. If the pin is still high, the bit is present again after a clearing read.
- R7: Selector codes 5, 6 and 7 never record an event, whatever the pin does.
- R8: Writing offset 0x0 sets every mask bit written as 1 and leaves the other bits unchanged. The mask is read back at offset 0x8.
- R9: Writing offset 0x4 clears every mask bit written as 1 and leaves the other bits unchanged.
- R10: A read of offset 0xC returns the status as it was before the read, then clears every bit that has no new event in that cycle.
- R11: Status bits are recorded whatever the mask holds. `irq_o` is high exactly when some bit is set in both the status and the mask.
- R12: An event detected in the same cycle as a status read is not lost. It is returned by the following status read.
- R13: An event is recorded on the third rising clock edge after the pin changes, counting the two synchronizer stages. `irq_o` follows from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Asynchronous pin levels |
| evt_sel_i | input | 96 | 3-bit event selector per pin; pin n uses bits [3n+2:3n] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data, valid the cycle after `reg_rd_i` |
| irq_o | output | 1 | Combined interrupt for the group |

## Verification
The status register has two jobs that can land in the same clock edge: clearing on a read and recording a freshly detected event. The bench provokes this by changing a pin configured for any edge. It waits exactly the two synchronizer edges and then issues the status read, so the read is sampled on the edge where the detector fires. The read must return zero for that pin, and the next read must return the pin's bit. A level-selected pin that stays active through a read provides the same collision every cycle, and the bench judges it by reading the bit twice in a row.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int REG_AW = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_kind_e;

  localparam logic [REG_AW-1:0] OFS_EN_SET = 4'h0;
  localparam logic [REG_AW-1:0] OFS_EN_CLR = 4'h4;
  localparam logic [REG_AW-1:0] OFS_MASK   = 4'h8;
  localparam logic [REG_AW-1:0] OFS_STAT   = 4'hC;
endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      last_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      last_q <= stg_q[STAGES-1];
    end
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = last_q;
endmodule

// File: rtl/pin_evt_detect.sv
module pin_evt_detect
  import pin_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cur_i,
  input  logic             prev_i,
  output logic             hit_o
);
  always_comb begin
    case (sel_i)
      EVT_FALL: hit_o = prev_i & ~cur_i;
      EVT_RISE: hit_o = ~prev_i & cur_i;
      EVT_BOTH: hit_o = prev_i ^ cur_i;
      EVT_LOW:  hit_o = ~cur_i;
      EVT_HIGH: hit_o = cur_i;
      default:  hit_o = 1'b0;
    endcase
  end

  a_r7_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > 3'd4) |-> !hit_o);
  a_r2_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EVT_FALL && hit_o) |-> (prev_i && !cur_i));
  a_r3_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EVT_RISE && hit_o) |-> (!prev_i && cur_i));
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] hit_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] mask_q, status_q, rdata_q;
  logic                set_we, clr_we, stat_rd;

  assign set_we  = wr_i && (addr_i == OFS_EN_SET);
  assign clr_we  = wr_i && (addr_i == OFS_EN_CLR);
  assign stat_rd = rd_i && (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (set_we) begin
      mask_q <= mask_q | wdata_i;
    end else if (clr_we) begin
      mask_q <= mask_q & ~wdata_i;
    end
  end

  // new events win over the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (stat_rd ? '0 : status_q) | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      case (addr_i)
        OFS_MASK: rdata_q <= mask_q;
        OFS_STAT: rdata_q <= status_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(status_q & mask_q);

  a_r8_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_EN_SET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  a_r9_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_EN_CLR) |=> ((mask_q & $past(wdata_i)) == '0));
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_STAT) |=> ((status_q & ~$past(hit_i)) == '0));
  a_r12_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((status_q & $past(hit_i)) == $past(hit_i)));
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == OFS_STAT) |=> ((status_q & $past(status_q)) == $past(status_q)));
  a_r11_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|mask_q));
endmodule

// File: rtl/pin_evt_irq_ctrl.sv
module pin_evt_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_i,
  input  logic [NUM_PINS*SEL_W-1:0] evt_sel_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [REG_AW-1:0]         reg_addr_i,
  input  logic [NUM_PINS-1:0]       reg_wdata_i,
  output logic [NUM_PINS-1:0]       reg_rdata_o,
  output logic                      irq_o
);
  logic [NUM_PINS-1:0] pin_cur, pin_prev, hit;

  pin_sync_bank #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .cur_o   (pin_cur),
    .prev_o  (pin_prev)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_evt_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (evt_sel_i[p*SEL_W +: SEL_W]),
      .cur_i  (pin_cur[p]),
      .prev_i (pin_prev[p]),
      .hit_o  (hit[p])
    );
  end

  evt_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/pin_evt_irq_ctrl_tb_top.sv
module pin_evt_irq_ctrl_tb_top;
  localparam int NP = 32;
  localparam logic [3:0] A_SET  = 4'h0;
  localparam logic [3:0] A_CLR  = 4'h4;
  localparam logic [3:0] A_MASK = 4'h8;
  localparam logic [3:0] A_STAT = 4'hC;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin_r = '0;
  logic [NP-1:0][2:0] sel_r = '0;
  logic            wr_r = 1'b0, rd_r = 1'b0;
  logic [3:0]      addr_r = '0;
  logic [NP-1:0]   wdata_r = '0;
  logic [NP-1:0]   rdata;
  logic            irq;
  logic            rd_d1 = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [NP-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;

  pin_evt_irq_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin_r),
    .evt_sel_i   (sel_r),
    .reg_wr_i    (wr_r),
    .reg_rd_i    (rd_r),
    .reg_addr_i  (addr_r),
    .reg_wdata_i (wdata_r),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  always @(posedge clk) rd_d1 <= rd_r;

  // monitor: read data is valid one cycle after the strobe
  always @(negedge clk) begin
    if (rd_d1) begin
      logic [NP-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: read 0x%08h expected 0x%08h", t, rdata, e);
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq %0b expected %0b", t, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    wr_r = 1'b1; addr_r = a; wdata_r = d;
    @(negedge clk);
    wr_r = 1'b0; wdata_r = '0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [NP-1:0] e, input string t);
    @(negedge clk);
    rd_r = 1'b1; addr_r = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_r = 1'b0;
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pin_r[p] = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    @(negedge clk) check_bit(irq, 1'b0, "R1 irq after reset");
    rd_reg(A_MASK, '0, "R1 mask after reset");
    rd_reg(A_STAT, '0, "R1 status after reset");

    // R8 / R9 mask set and clear ports
    wr_reg(A_SET, 32'h0000_00F0);
    rd_reg(A_MASK, 32'h0000_00F0, "R8 set bits");
    wr_reg(A_SET, 32'h0);
    rd_reg(A_MASK, 32'h0000_00F0, "R8 zero write no effect");
    wr_reg(A_CLR, 32'h0000_0030);
    rd_reg(A_MASK, 32'h0000_00C0, "R9 clear bits");
    wr_reg(A_CLR, 32'h0);
    rd_reg(A_MASK, 32'h0000_00C0, "R9 zero write no effect");
    wr_reg(A_CLR, '1);
    rd_reg(A_MASK, '0, "R9 clear all");

    // R3 rising edge, R10 clear on read
    @(negedge clk) sel_r[1] = 3'd1;
    set_pin(1, 1'b1); settle();
    rd_reg(A_STAT, 32'h2, "R3 rising recorded");
    rd_reg(A_STAT, 32'h0, "R10 status cleared by read");
    set_pin(1, 1'b0); settle();
    rd_reg(A_STAT, 32'h0, "R3 falling ignored");

    // R2 falling edge
    set_pin(2, 1'b1); settle();
    rd_reg(A_STAT, 32'h0, "R2 rising ignored");
    set_pin(2, 1'b0); settle();
    rd_reg(A_STAT, 32'h4, "R2 falling recorded");

    // R4 both edges
    @(negedge clk) sel_r[3] = 3'd2;
    set_pin(3, 1'b1); settle();
    rd_reg(A_STAT, 32'h8, "R4 rise recorded");
    set_pin(3, 1'b0); settle();
    rd_reg(A_STAT, 32'h8, "R4 fall recorded");

    // R6 high level
    @(negedge clk) sel_r[4] = 3'd4;
    set_pin(4, 1'b1); settle();
    rd_reg(A_STAT, 32'h10, "R6 high level");
    rd_reg(A_STAT, 32'h10, "R6 high level again after read");
    set_pin(4, 1'b0); settle();
    rd_reg(A_STAT, 32'h10, "R6 residual before sync low");
    rd_reg(A_STAT, 32'h0, "R6 level gone");

    // R5 low level
    @(negedge clk) sel_r[5] = 3'd3;
    settle();
    rd_reg(A_STAT, 32'h20, "R5 low level");
    rd_reg(A_STAT, 32'h20, "R5 low level again after read");
    set_pin(5, 1'b1); settle();
    rd_reg(A_STAT, 32'h20, "R5 residual before sync high");
    rd_reg(A_STAT, 32'h0, "R5 level gone");

    // R7 unused codes
    @(negedge clk) begin
      sel_r[6] = 3'd5; sel_r[7] = 3'd6; sel_r[8] = 3'd7;
      pin_r[6] = 1'b1; pin_r[7] = 1'b1; pin_r[8] = 1'b1;
    end
    settle();
    rd_reg(A_STAT, 32'h0, "R7 high on unused codes");
    @(negedge clk) begin
      pin_r[6] = 1'b0; pin_r[7] = 1'b0; pin_r[8] = 1'b0;
    end
    settle();
    rd_reg(A_STAT, 32'h0, "R7 low on unused codes");

    // R11 status latched while masked, irq gated by mask
    set_pin(1, 1'b1); settle();
    @(negedge clk) check_bit(irq, 1'b0, "R11 masked event no irq");
    wr_reg(A_SET, 32'h2);
    check_bit(irq, 1'b1, "R11 irq after unmask");
    rd_reg(A_STAT, 32'h2, "R11 status kept while masked");
    check_bit(irq, 1'b0, "R11 irq drops after read");

    // R13 latency through synchronizer
    set_pin(1, 1'b0); settle();
    rd_reg(A_STAT, 32'h0, "R13 falling ignored on rise pin");
    @(negedge clk) pin_r[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) check_bit(irq, 1'b0, "R13 irq not before third edge");
    @(posedge clk);
    @(negedge clk) check_bit(irq, 1'b1, "R13 irq at third edge");
    rd_reg(A_STAT, 32'h2, "R13 status value");

    // R12 event in the same cycle as a status read
    rd_reg(A_STAT, 32'h0, "R12 status clean");
    @(negedge clk) pin_r[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd_reg(A_STAT, 32'h0, "R12 read in event cycle");
    rd_reg(A_STAT, 32'h8, "R12 event kept");

    wr_reg(A_CLR, '1);
    set_pin(1, 1'b0); settle();
    @(negedge clk) check_bit(irq, 1'b0, "R11 irq low with empty mask");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule